// File: doc/BRIEF.md
# Divided Local Countdown Timer

A per-processor countdown timer clocked from the system clock through a programmable power-of-two prescaler. Software loads a start value into the initial-count register. The current count then steps down by one every 2^shift clock cycles. The shift comes from a divide-configuration register that uses an unusual three-bit encoding, in which the largest code wraps round to divide-by-one.

A timer entry register sets the behaviour at expiry. It holds a vector, a mask bit and a periodic/one-shot select. In one-shot mode the count stops at zero. In periodic mode, on the step after reaching zero, it reloads the initial value. Each time the count steps from one to zero with the entry unmasked, the block raises a one-cycle interrupt request that carries the vector.

Registers are reached through write and read strobes with a two-bit index:
- index 0: timer entry
- index 1: initial count
- index 2: current count, read-only
- index 3: divide configuration

Read data is registered and appears in the cycle after the read strobe. Writing the initial count restarts both the count and the prescaler phase.

Top module: `lct_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0), the initial count, the current count and the divide register read 0, and irq_valid is low.
- R2: A write to the divide register (index 3) keeps only bits 0, 1 and 3 (mask 0xB), and a read returns the kept value.
- R3: The divide code is {bit3, bit1, bit0}, and the prescale shift is (code+1) mod 8, so divide value 0xB gives divide-by-1. The count decreases by one every 2^shift clock cycles, counted from the initial-count write.
- R4: In one-shot mode (entry bit 17 = 0) the current count equals initial minus elapsed steps and then holds at 0.
- R5: In periodic mode (entry bit 17 = 1) the step after the count reaches 0 reloads the initial value, giving initial minus (elapsed mod (initial+1)).
- R6: When the count steps from 1 to 0, irq_valid is high for exactly one cycle, in the cycle in which the count first reads 0, with irq_vector equal to entry bits [7:0].
- R7: While entry bit 16 (mask) is set, no interrupt request is issued, but the count keeps running.
- R8: Writing the initial count (index 1) reloads the count and restarts the prescaler phase at that write.
- R9: An initial count of 0 keeps the timer stopped at 0 with no interrupt request, in either mode.
- R10: The entry keeps only bits 17, 16 and 7:0, and the other bits read 0. Writes to the current-count index (2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 2 | Register index (0 entry, 1 initial, 2 current, 3 divide) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq_valid | output | 1 | One-cycle interrupt request at expiry |
| irq_vector | output | 8 | Vector sent with the request |

## Verification
The bench builds the timer with a 16-bit count width. Small initial values then reach expiry and periodic reload within a handful of cycles. The same values still leave room for the slowest prescale setting (divide-by-128) to show no step at all inside a short window. A table of divide values covers every shift, including the wrap to divide-by-one and the effect of the ignored bit 2. Directed cases time the interrupt pulse to the exact cycle and show that the prescaler phase restarts on reload.

// File: rtl/lct_timer_pkg.sv
package lct_timer_pkg;
    localparam int DATA_W  = 32;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int DIV_W   = 4;
    localparam int IDX_W   = 2;

    localparam logic [IDX_W-1:0] IDX_ENTRY = 2'd0;
    localparam logic [IDX_W-1:0] IDX_INIT  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_COUNT = 2'd2;
    localparam logic [IDX_W-1:0] IDX_DIV   = 2'd3;

    localparam int BIT_MASK     = 16;
    localparam int BIT_PERIODIC = 17;
    localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

    // Shift = ({b3,b1,b0} + 1) mod 8
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
        logic [SHIFT_W-1:0] code;
        code = {d[3], d[1:0]};
        return code + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit = (PRE_W'(1) << shift) - PRE_W'(1);
        tick  = (st_q.phase >= limit);
        st_d  = st_q;
        if (restart || tick) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = tick && !load && (st_q.cnt == CNT_W'(1));
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end else if (periodic) begin
                st_d.cnt = init_val;
            end
        end
    end

    assign count = st_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    typedef struct packed {
        logic              mask;
        logic              periodic;
        logic [VEC_W-1:0]  vector;
        logic [CNT_W-1:0]  init;
        logic [DIV_W-1:0]  div;
        logic              irq;
        logic [VEC_W-1:0]  irq_vec;
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic               load;
    logic               tick;
    logic               expire;
    logic [CNT_W-1:0]   cnt;
    logic [SHIFT_W-1:0] shift;

    assign load  = wr_en && (reg_idx == IDX_INIT);
    assign shift = div_to_shift(st_q.div);

    lct_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (shift),
        .tick    (tick)
    );

    lct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (wr_data[CNT_W-1:0]),
        .tick     (tick),
        .periodic (st_q.periodic),
        .init_val (st_q.init),
        .count    (cnt),
        .expire   (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = expire && !st_q.mask;
        if (expire) begin
            st_d.irq_vec = st_q.vector;
        end
        if (wr_en) begin
            unique case (reg_idx)
                IDX_ENTRY: begin
                    st_d.mask     = wr_data[BIT_MASK];
                    st_d.periodic = wr_data[BIT_PERIODIC];
                    st_d.vector   = wr_data[VEC_W-1:0];
                end
                IDX_INIT: st_d.init = wr_data[CNT_W-1:0];
                IDX_DIV:  st_d.div  = wr_data[DIV_W-1:0] & DIV_KEEP;
                default: ;
            endcase
        end
        if (rd_en) begin
            unique case (reg_idx)
                IDX_ENTRY: begin
                    st_d.rdata = '0;
                    st_d.rdata[BIT_PERIODIC] = st_q.periodic;
                    st_d.rdata[BIT_MASK]     = st_q.mask;
                    st_d.rdata[VEC_W-1:0]    = st_q.vector;
                end
                IDX_INIT:  st_d.rdata = DATA_W'(st_q.init);
                IDX_COUNT: st_d.rdata = DATA_W'(cnt);
                default:   st_d.rdata = DATA_W'(st_q.div);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rdata;
    assign irq_valid  = st_q.irq;
    assign irq_vector = st_q.irq_vec;
endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk
    import lct_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] reg_idx,
    input logic             irq_valid,
    input logic             mask,
    input logic             periodic,
    input logic [CNT_W-1:0] init,
    input logic [CNT_W-1:0] count
);
    // R6: the request never lasts two cycles
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R6: the request coincides with a zero count
    a_r6_zero_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (count == '0));

    // R7: a masked entry at decision time blocks the request
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(mask));

    // R4: one-shot count stays at zero unless reloaded
    a_r4_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && count == '0 && !(wr_en && reg_idx == IDX_INIT)) |=> (count == '0));

    // R9: zero initial count never raises a request
    a_r9_zero_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (init == '0) |-> !irq_valid);

    // R5: the count never exceeds the initial value
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= init);
endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_idx   (reg_idx),
    .irq_valid (irq_valid),
    .mask      (st_q.mask),
    .periodic  (st_q.periodic),
    .init      (st_q.init),
    .count     (cnt)
);

// File: tb/test_lct_timer.sv
module test_lct_timer;
    localparam int CNT_W = 16;
    localparam int NV    = 10;

    // divide write, expected readback, expected count after 20 cycles from load of 100
    localparam logic [3:0]  DIV_IN [NV] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'hB, 4'hF, 4'hA, 4'h4, 4'h9};
    localparam logic [3:0]  DIV_RB [NV] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'hB, 4'hB, 4'hA, 4'h0, 4'h9};
    localparam logic [31:0] EXP_C  [NV] = '{32'd90, 32'd95, 32'd98, 32'd99, 32'd100,
                                           32'd80, 32'd80, 32'd100, 32'd90, 32'd100};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    logic [7:0] last_vec = '0;

    always #2 clk = ~clk;

    lct_timer #(.CNT_W(CNT_W)) i_lct_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
        .wr_data(wr_data), .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always @(negedge clk) begin
        if (irq_valid) begin
            pulses   <= pulses + 1;
            last_vec <= irq_vector;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        wr_en = 1'b1; reg_idx = idx; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        rd_en = 1'b1; reg_idx = idx;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        check("R1 irq", {31'd0, irq_valid}, 32'd0);
        rd(2'd0, v); check("R1 entry", v, 32'h0001_0000);
        rd(2'd1, v); check("R1 init", v, 32'd0);
        rd(2'd2, v); check("R1 count", v, 32'd0);
        rd(2'd3, v); check("R1 div", v, 32'd0);

        // R2/R3 divide table
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, {28'd0, DIV_IN[i]});
            rd(2'd3, v); check("R2 div readback", v, {28'd0, DIV_RB[i]});
            wr(2'd1, 32'd100);
            cyc(20);
            rd(2'd2, v); check("R3 count after 20 cycles", v, EXP_C[i]);
        end

        // R6 one-shot expiry timing, divide-by-1
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0000_005A);
        base = pulses;
        wr(2'd1, 32'd3);
        cyc(1); check("R6 no irq at step 1", {31'd0, irq_valid}, 32'd0);
        cyc(1); check("R6 no irq at step 2", {31'd0, irq_valid}, 32'd0);
        cyc(1); check("R6 irq at zero", {31'd0, irq_valid}, 32'd1);
        check("R6 vector", {24'd0, irq_vector}, 32'h5A);
        cyc(1); check("R6 irq single cycle", {31'd0, irq_valid}, 32'd0);
        cyc(6);
        check("R6 one pulse", pulses - base, 32'd1);
        rd(2'd2, v); check("R4 one-shot holds zero", v, 32'd0);

        // R7 masked
        wr(2'd0, 32'h0001_0033);
        base = pulses;
        wr(2'd1, 32'd3);
        cyc(10);
        check("R7 masked no pulse", pulses - base, 32'd0);
        rd(2'd2, v); check("R7 count still ran", v, 32'd0);

        // R5 periodic reload
        wr(2'd0, 32'h0002_0077);
        base = pulses;
        wr(2'd1, 32'd2);
        cyc(3);
        rd(2'd2, v); check("R5 reload after zero", v, 32'd2);
        cyc(5);
        check("R5 periodic pulses", pulses - base, 32'd3);
        check("R5 periodic vector", {24'd0, last_vec}, 32'h77);

        // R8 restart of prescaler phase, divide-by-2
        wr(2'd0, 32'h0001_0000);
        wr(2'd3, 32'h0);
        wr(2'd1, 32'd10);
        cyc(4);
        wr(2'd1, 32'd10);
        cyc(1);
        rd(2'd2, v); check("R8 phase restarted", v, 32'd10);
        rd(2'd2, v); check("R8 first step", v, 32'd9);

        // R9 zero initial count
        wr(2'd0, 32'h0002_0011);
        wr(2'd3, 32'hB);
        wr(2'd1, 32'd0);
        base = pulses;
        cyc(20);
        check("R9 no pulse", pulses - base, 32'd0);
        rd(2'd2, v); check("R9 count stays zero", v, 32'd0);

        // R10 entry fields and read-only count
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R10 entry fields", v, 32'h0003_00FF);
        wr(2'd0, 32'h0001_0000);
        wr(2'd3, 32'hA);
        wr(2'd1, 32'd50);
        wr(2'd2, 32'h1234);
        rd(2'd2, v); check("R10 count write ignored", v, 32'd50);
        rd(2'd1, v); check("R10 init intact", v, 32'd50);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule